// File: doc/BRIEF.md
# Word Rotate-and-Mask Unit

This datapath block takes a 32-bit source word and rotates it toward the most significant end by a 5-bit amount. It also builds a contiguous bit mask from a begin index and an end index, and uses that mask to form the result. Bit positions are counted from the most significant end: position 0 is the sign bit and position 31 is the least significant bit. When the begin index is greater than the end index, the mask wraps around the end of the word.

Two result modes are available. In masked mode, the rotated value is kept where the mask is set and every other bit is cleared. In merge mode, the rotated value replaces the bits of a target word where the mask is set, and the target bits outside the mask are kept. These two modes cover many operations by choice of amount and indices alone: field extraction with left or right justification, field insertion, plain rotation, logical shifts, clearing of high or low bits, and clear-then-scale of an index. The record-form request travels through the block alongside the result, so that a downstream unit can derive sign and zero flags from the result.

The block registers its result and takes one clock from accepted input to output. It has a synchronous active-high reset.

Top module: `word_rotmask`

## Requirements
- R1: Bit position p (0..31) of every word port maps to vector index 31-p, so position 0 is the MSB (index 31).
- R2: The source is rotated toward the MSB by `rot_amt` places. Bits that leave at index 31 re-enter at index 0. An amount of 0 leaves the source unchanged.
- R3: When `mask_lo <= mask_hi`, the mask holds exactly the positions `mask_lo` through `mask_hi` inclusive, which is `mask_hi - mask_lo + 1` set bits.
- R4: When `mask_lo > mask_hi`, the mask wraps: positions `mask_lo` through 31 and positions 0 through `mask_hi` are set, and the positions in between are clear.
- R5: With `mode_ins = 0` (masked mode), the result is the rotated source ANDed with the mask, so every bit outside the mask is zero.
- R6: With `mode_ins = 1` (merge mode), the result takes the rotated source inside the mask and `tgt_word` outside the mask.
- R7: `rec_out` equals the `rec_in` value that was sampled with the same accepted input, on the same cycle as its result.
- R8: When `in_valid` is high on a rising edge, `out_valid` is high after that edge and the result appears then. When `in_valid` is low, `out_valid` goes low and `result` and `rec_out` keep their previous values.
- R9: While `rst` is high at a clock edge, `result` and `rec_out` clear to 0 and `out_valid` clears to 0.
- R10: The derived operations come out exactly as described here, with n the shift count and b the bit position:
  - Amount n with mask 0..31-n gives a logical left shift by n.
  - Amount 32-n with mask n..31 gives a logical right shift by n.
  - Amount 32-(b+n) with mask b..b+n-1 in merge mode inserts the low n source bits at position b.
  - Amount n with mask b-n..31-n clears the top b bits and then shifts left by n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands are present this cycle |
| src_word | input | 32 | Word to be rotated |
| tgt_word | input | 32 | Word that supplies the bits outside the mask in merge mode |
| rot_amt | input | 5 | Rotate-toward-MSB amount |
| mask_lo | input | 5 | Mask begin position (MSB-first numbering) |
| mask_hi | input | 5 | Mask end position (MSB-first numbering) |
| mode_ins | input | 1 | 0 = masked mode, 1 = merge mode |
| rec_in | input | 1 | Record-form request accompanying the operands |
| out_valid | output | 1 | Result is valid |
| result | output | 32 | Registered result word |
| rec_out | output | 1 | Record-form request aligned with `result` |

## Verification
The block holds no state apart from its output register, so any fault appears at the ports on the first result after the offending input.

A fault in the mask generator has a direct signature. In masked mode it leaves stray ones outside the requested range or drops bits inside it. In merge mode it lets target bits leak into the field or leaves holes in the field. A reversed bit numbering or a wrong rotate stage shows up as a shifted or bit-reversed field.

The sweep covers every amount, begin and end combination in both modes, including all the wrap-around masks. It therefore sees each such fault one cycle after the first input that exposes it.

// File: rtl/rotmask_pkg.sv
package rotmask_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned AMT_W  = $clog2(WORD_W);

  typedef enum logic {
    RM_MASKED = 1'b0,
    RM_MERGE  = 1'b1
  } rm_mode_e;
endpackage

// File: rtl/rotmask_rotator.sv
module rotmask_rotator #(
  parameter int unsigned W     = 32,
  parameter int unsigned SH_W  = $clog2(W)
) (
  input  logic [W-1:0]    din,
  input  logic [SH_W-1:0] amt,
  output logic [W-1:0]    dout
);
  // One stage per bit of the amount; stage s rotates by 2**s toward the MSB.
  logic [W-1:0] stage [SH_W+1];

  assign stage[0] = din;

  for (genvar s = 0; s < SH_W; s++) begin : g_stage
    localparam int unsigned K = 1 << s;
    logic [W-1:0] turned;
    assign turned = {stage[s][W-1-K:0], stage[s][W-1:W-K]};
    assign stage[s+1] = amt[s] ? turned : stage[s];
  end

  assign dout = stage[SH_W];
endmodule

// File: rtl/rotmask_maskgen.sv
module rotmask_maskgen #(
  parameter int unsigned W     = 32,
  parameter int unsigned SH_W  = $clog2(W)
) (
  input  logic [SH_W-1:0] lo,
  input  logic [SH_W-1:0] hi,
  output logic [W-1:0]    mask
);
  logic straight;
  assign straight = (lo <= hi);

  // Position p is counted from the MSB, so it lands at vector index W-1-p.
  for (genvar p = 0; p < W; p++) begin : g_bit
    localparam logic [SH_W-1:0] POS = SH_W'(p);
    logic after_lo;
    logic before_hi;
    assign after_lo  = (POS >= lo);
    assign before_hi = (POS <= hi);
    assign mask[W-1-p] = straight ? (after_lo & before_hi) : (after_lo | before_hi);
  end
endmodule

// File: rtl/rotmask_merge.sv
module rotmask_merge
  import rotmask_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] rotated,
  input  logic [W-1:0] tgt,
  input  logic [W-1:0] mask,
  input  rm_mode_e     mode,
  output logic [W-1:0] merged
);
  logic [W-1:0] keep;

  always_comb begin
    keep = (mode == RM_MERGE) ? (tgt & ~mask) : '0;
    merged = (rotated & mask) | keep;
  end
endmodule

// File: rtl/word_rotmask.sv
module word_rotmask
  import rotmask_pkg::*;
#(
  parameter int unsigned W    = WORD_W,
  parameter int unsigned SH_W = $clog2(W)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [W-1:0]    src_word,
  input  logic [W-1:0]    tgt_word,
  input  logic [SH_W-1:0] rot_amt,
  input  logic [SH_W-1:0] mask_lo,
  input  logic [SH_W-1:0] mask_hi,
  input  logic            mode_ins,
  input  logic            rec_in,
  output logic            out_valid,
  output logic [W-1:0]    result,
  output logic            rec_out
);
  logic [W-1:0] rot_w;
  logic [W-1:0] mask_w;
  logic [W-1:0] merged_w;
  rm_mode_e     mode_w;

  assign mode_w = rm_mode_e'(mode_ins);

  rotmask_rotator #(.W(W), .SH_W(SH_W)) u_rot (
    .din  (src_word),
    .amt  (rot_amt),
    .dout (rot_w)
  );

  rotmask_maskgen #(.W(W), .SH_W(SH_W)) u_mask (
    .lo   (mask_lo),
    .hi   (mask_hi),
    .mask (mask_w)
  );

  rotmask_merge #(.W(W)) u_merge (
    .rotated (rot_w),
    .tgt     (tgt_word),
    .mask    (mask_w),
    .mode    (mode_w),
    .merged  (merged_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
      rec_out   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result  <= merged_w;
        rec_out <= rec_in;
      end
    end
  end

  // R3
  mask_count_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mask_lo <= mask_hi) |->
      ($countones(mask_w) == (int'(mask_hi) - int'(mask_lo) + 1)));

  // R4
  mask_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mask_lo > mask_hi) |->
      ($countones(mask_w) == (int'(W) - int'(mask_lo) + int'(mask_hi) + 1)));

  // R5
  masked_zero_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(in_valid) && !$past(mode_ins)) |-> ((result & ~$past(mask_w)) == '0));

  // R6
  merge_keep_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(in_valid) && $past(mode_ins)) |->
      ((result & ~$past(mask_w)) == ($past(tgt_word) & ~$past(mask_w))));

  // R2
  rot_zero_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(in_valid) && $past(rot_amt) == '0 && $past(mask_lo) == '0 &&
     $past(mask_hi) == SH_W'(W-1) && !$past(mode_ins)) |-> (result == $past(src_word)));

  // R7
  rec_pass_chk: assert property (@(posedge clk) disable iff (rst)
    $past(in_valid) |-> (rec_out == $past(rec_in)));

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!in_valid && !$past(rst)) |=> ($stable(result) && !out_valid));

  // R9
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!out_valid && result == '0 && !rec_out));
endmodule

// File: tb/tb_word_rotmask.sv
module tb_word_rotmask;
  localparam int W = 32;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] src_word = '0;
  logic [31:0] tgt_word = '0;
  logic [4:0]  rot_amt = '0;
  logic [4:0]  mask_lo = '0;
  logic [4:0]  mask_hi = '0;
  logic        mode_ins = 1'b0;
  logic        rec_in = 1'b0;
  logic        out_valid;
  logic [31:0] result;
  logic        rec_out;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  word_rotmask dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .src_word(src_word),
    .tgt_word(tgt_word), .rot_amt(rot_amt), .mask_lo(mask_lo),
    .mask_hi(mask_hi), .mode_ins(mode_ins), .rec_in(rec_in),
    .out_valid(out_valid), .result(result), .rec_out(rec_out)
  );

  function automatic logic [31:0] ref_rot(input logic [31:0] v, input int a);
    logic [63:0] dbl;
    dbl = {v, v} << a;
    return dbl[63:32];
  endfunction

  function automatic logic [31:0] ref_mask(input int lo, input int hi);
    logic [31:0] m;
    m = '0;
    for (int p = 0; p < 32; p++) begin
      if (lo <= hi) m[31-p] = (p >= lo && p <= hi);
      else          m[31-p] = (p >= lo || p <= hi);
    end
    return m;
  endfunction

  task automatic check32(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [31:0] s, input logic [31:0] t, input int a,
                       input int lo, input int hi, input logic md, input logic rc);
    in_valid = 1'b1;
    src_word = s; tgt_word = t;
    rot_amt = 5'(a); mask_lo = 5'(lo); mask_hi = 5'(hi);
    mode_ins = md; rec_in = rc;
    @(negedge clk);
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 190000) begin
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
      end
    end
  end

  initial begin
    logic [31:0] expv;
    logic [31:0] held;
    repeat (3) @(negedge clk);
    // R9 reset state
    check32("R9 result", result, 32'h0);
    check32("R9 valid", {31'b0, out_valid}, 32'h0);
    check32("R9 rec", {31'b0, rec_out}, 32'h0);
    rst = 1'b0;

    // R1 position 0 is the MSB
    drive(32'hFFFF_FFFF, 32'h0, 0, 0, 0, 1'b0, 1'b0);
    check32("R1 msb", result, 32'h8000_0000);
    drive(32'hFFFF_FFFF, 32'h0, 0, 31, 31, 1'b0, 1'b0);
    check32("R1 lsb", result, 32'h0000_0001);
    // R2 rotate toward MSB, wrap of top bit
    drive(32'h8000_0001, 32'h0, 1, 0, 31, 1'b0, 1'b0);
    check32("R2 rot1", result, 32'h0000_0003);
    drive(32'hDEAD_BEEF, 32'h0, 0, 0, 31, 1'b0, 1'b0);
    check32("R2 rot0", result, 32'hDEAD_BEEF);
    // R7 record flag alignment
    drive(32'h1, 32'h0, 0, 0, 31, 1'b0, 1'b1);
    check32("R7 rec1", {31'b0, rec_out}, 32'h1);
    check32("R8 valid", {31'b0, out_valid}, 32'h1);
    drive(32'h1, 32'h0, 0, 0, 31, 1'b0, 1'b0);
    check32("R7 rec0", {31'b0, rec_out}, 32'h0);
    // R8 hold when idle
    held = result;
    in_valid = 1'b0; src_word = 32'h5555_AAAA; rec_in = 1'b1;
    @(negedge clk);
    check32("R8 hold", result, held);
    check32("R8 idle", {31'b0, out_valid}, 32'h0);
    check32("R8 rec hold", {31'b0, rec_out}, 32'h0);
    // R10 derived operations
    drive(32'h1234_5678, 32'h0, 8, 0, 23, 1'b0, 1'b0);
    check32("R10 shl8", result, 32'h3456_7800);
    drive(32'h1234_5678, 32'h0, 28, 4, 31, 1'b0, 1'b0);
    check32("R10 shr4", result, 32'h0123_4567);
    drive(32'h8000_0000, 32'h0, 1, 31, 31, 1'b0, 1'b0);
    check32("R10 extract sign", result, 32'h0000_0001);
    drive(32'h0000_0001, 32'h0000_FFFF, 31, 0, 0, 1'b1, 1'b0);
    check32("R10 insert", result, 32'h8000_FFFF);
    drive(32'hFFFF_FFFF, 32'h0, 4, 12, 27, 1'b0, 1'b0);
    check32("R10 clear-shift", result, 32'h000F_FFF0);
    drive(32'hFFFF_FFFF, 32'h0, 0, 16, 31, 1'b0, 1'b0);
    check32("R10 clear-left", result, 32'h0000_FFFF);

    // R3 R4 R5 R6 exhaustive sweep over amount, begin, end in both modes
    for (int md = 0; md < 2; md++) begin
      for (int a = 0; a < 32; a++) begin
        for (int lo = 0; lo < 32; lo++) begin
          for (int hi = 0; hi < 32; hi++) begin
            logic [31:0] s;
            logic [31:0] t;
            logic [31:0] m;
            s = 32'hA5C3_1E97 ^ (32'(a) * 32'h9E37_79B9) ^ (32'(lo) << 11) ^ 32'(hi * 977);
            t = ~s ^ 32'h0F0F_3C3C ^ (32'(hi) << 20);
            m = ref_mask(lo, hi);
            expv = (md == 1) ? ((ref_rot(s, a) & m) | (t & ~m)) : (ref_rot(s, a) & m);
            drive(s, t, a, lo, hi, 1'(md), 1'(hi & 1));
            if (md == 1) begin
              if (lo <= hi) check32("R6 merge R3 mask", result, expv);
              else          check32("R6 merge R4 wrap", result, expv);
            end else begin
              if (lo <= hi) check32("R5 masked R3 mask", result, expv);
              else          check32("R5 masked R4 wrap", result, expv);
            end
          end
        end
      end
    end
    in_valid = 1'b0;
    // R9 reset again after activity
    rst = 1'b1;
    @(negedge clk);
    check32("R9 reclear", result, 32'h0);
    rst = 1'b0;
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule